// File: doc/BRIEF.md
# Two-Layer Alpha Pixel Blender

This block takes one foreground pixel and one background pixel, both in 32-bit ARGB form, and merges them into a single ARGB result. It uses the "over" composite in pure integer arithmetic. First it forms a combined alpha term from the two source alphas. From that it derives the output alpha. Each colour channel is then a weighted sum of the two sources divided by the output alpha, and every division rounds down, so the result follows one exact integer formula.

Pixel pairs enter through a valid/ready stream. They leave through a second valid/ready stream after a fixed three-stage pipeline: alpha terms, numerators, then division. The pipeline moves only when its last stage is empty or being drained, so back-pressure freezes every stage in place. A 2-bit mode input travels with each pair. One code value selects blending, and every other value sends the foreground pixel through unchanged with the same latency. The block has no configuration registers.

Top module: `alpha_over_blender`

## Requirements
- R1: Pixels are packed with alpha in bits 31:24, red in 23:16, green in 15:8 and blue in 7:0. Each accepted pair yields exactly one output pixel, and outputs leave in acceptance order.
- R2: The combined alpha is am = floor(a_fg * a_bg / 255), and it never exceeds a_bg.
- R3: The output alpha, placed in bits 31:24 of a blended result, is a_fg + a_bg - am. It never exceeds 255.
- R4: Each of R, G and B is floor((c_fg*a_fg + c_bg*a_bg - c_bg*am) / a_out). For example, a_fg = 255 returns the foreground colour, and a_fg = 0 with a_bg = 255 returns the background colour.
- R5: The numerator is held at 18 bits, and the quotient always fits in 8 bits without saturation.
- R6: When the output alpha is 0, all three colour channels of the result are 0.
- R7: Mode value 2'b10 selects blending. Mode values 2'b00, 2'b01 and 2'b11 output the foreground pixel bit for bit, including its alpha.
- R8: With out_ready_i held high, a pair accepted at one clock edge appears on the output after the third edge, and one pair can be accepted every cycle.
- R9: While out_valid_o is high and out_ready_i is low, out_pix_o stays stable, out_valid_o stays high and in_ready_o is low, so no pair is accepted.
- R10: During reset out_valid_o is low and in_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input pair valid |
| in_ready_o | output | 1 | Pipeline can take a pair |
| mode_i | input | 2 | 2'b10 blend, other values pass foreground |
| fg_pix_i | input | 32 | Foreground ARGB pixel |
| bg_pix_i | input | 32 | Background ARGB pixel |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Downstream accepts result |
| out_pix_o | output | 32 | Result ARGB pixel |

## Verification
Several properties are checked on every cycle: the combined alpha never exceeds the background alpha, the output alpha sum stays within 8 bits, every quotient fits in a channel, a zero output alpha forces zero colour, and a stalled output holds its value. The exact values of the rounding, the pass-through modes, the three-cycle latency, the ordering under random stalls and the reset state can only be shown by the bench's scenarios. These scenarios compare each result with an independent model of the formula.

// File: rtl/blend_pkg.sv
package blend_pkg;
  parameter int unsigned CH_W      = 8;
  parameter int unsigned NUM_CH    = 3;
  parameter int unsigned PIX_W     = (NUM_CH + 1) * CH_W;
  parameter int unsigned NUM_W     = 2 * CH_W + 2;
  parameter int unsigned ALPHA_MAX = (1 << CH_W) - 1;

  typedef logic [1:0] mode_t;
  localparam mode_t MODE_BLEND = 2'b10;

  typedef logic [CH_W-1:0]              chan_t;
  typedef logic [NUM_CH-1:0][CH_W-1:0]  rgb_t;
  typedef logic [NUM_W-1:0]             num_t;

  typedef struct packed {
    mode_t              mode;
    logic [PIX_W-1:0]   fg;
    rgb_t               c_fg;
    rgb_t               c_bg;
    chan_t              a_fg;
    chan_t              a_bg;
    chan_t              a_mult;
    chan_t              a_out;
  } alpha_stage_t;

  typedef struct packed {
    mode_t                       mode;
    logic [PIX_W-1:0]            fg;
    logic [NUM_CH-1:0][NUM_W-1:0] num;
    chan_t                       a_out;
  } num_stage_t;
endpackage

// File: rtl/blend_alpha_stage.sv
module blend_alpha_stage
  import blend_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             valid_i,
  input  mode_t            mode_i,
  input  logic [PIX_W-1:0] fg_i,
  input  logic [PIX_W-1:0] bg_i,
  output logic             valid_o,
  output alpha_stage_t     data_o
);
  localparam int unsigned PW = 2 * CH_W;

  chan_t          a_fg, a_bg, a_mult;
  logic [PW-1:0]  prod;
  logic [CH_W:0]  sum;
  alpha_stage_t   nxt;

  assign a_fg   = fg_i[PIX_W-1 -: CH_W];
  assign a_bg   = bg_i[PIX_W-1 -: CH_W];
  assign prod   = {{CH_W{1'b0}}, a_fg} * {{CH_W{1'b0}}, a_bg};
  assign a_mult = CH_W'(prod / PW'(ALPHA_MAX));
  assign sum    = {1'b0, a_fg} + {1'b0, a_bg} - {1'b0, a_mult};

  always_comb begin
    nxt.mode   = mode_i;
    nxt.fg     = fg_i;
    nxt.c_fg   = fg_i[NUM_CH*CH_W-1:0];
    nxt.c_bg   = bg_i[NUM_CH*CH_W-1:0];
    nxt.a_fg   = a_fg;
    nxt.a_bg   = a_bg;
    nxt.a_mult = a_mult;
    nxt.a_out  = CH_W'(sum);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (en_i) begin
      valid_o <= valid_i;
      data_o  <= nxt;
    end
  end

  // output alpha must fit one channel
  assert_alpha_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (sum <= (CH_W+1)'(ALPHA_MAX)));
endmodule

// File: rtl/blend_num_stage.sv
module blend_num_stage
  import blend_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         valid_i,
  input  alpha_stage_t data_i,
  output logic         valid_o,
  output num_stage_t   data_o
);
  num_stage_t nxt;
  chan_t      bg_weight;

  // c_bg*a_bg - c_bg*am folded into one product
  assign bg_weight = data_i.a_bg - data_i.a_mult;

  always_comb begin
    nxt.mode  = data_i.mode;
    nxt.fg    = data_i.fg;
    nxt.a_out = data_i.a_out;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    always_comb begin
      nxt.num[ch] = NUM_W'(data_i.c_fg[ch]) * NUM_W'(data_i.a_fg)
                  + NUM_W'(data_i.c_bg[ch]) * NUM_W'(bg_weight);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (en_i) begin
      valid_o <= valid_i;
      data_o  <= nxt;
    end
  end

  assert_mult_le_bg_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (data_i.a_mult <= data_i.a_bg));
endmodule

// File: rtl/blend_div_stage.sv
module blend_div_stage
  import blend_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             valid_i,
  input  num_stage_t       data_i,
  output logic             valid_o,
  output mode_t            mode_o,
  output logic [PIX_W-1:0] pix_o
);
  rgb_t                         rgb;
  logic [NUM_CH-1:0][NUM_W-1:0] quo;
  logic [PIX_W-1:0]             nxt_pix;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    always_comb begin
      quo[ch] = '0;
      if (data_i.a_out != '0) quo[ch] = data_i.num[ch] / NUM_W'(data_i.a_out);
      rgb[ch] = CH_W'(quo[ch]);
    end

    assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |-> (quo[ch] <= NUM_W'(ALPHA_MAX)));
  end

  assign nxt_pix = (data_i.mode == MODE_BLEND) ? {data_i.a_out, rgb} : data_i.fg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      mode_o  <= '0;
      pix_o   <= '0;
    end else if (en_i) begin
      valid_o <= valid_i;
      mode_o  <= data_i.mode;
      pix_o   <= nxt_pix;
    end
  end

  assert_zero_alpha_black_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && mode_o == MODE_BLEND && pix_o[PIX_W-1 -: CH_W] == '0)
      |-> (pix_o[NUM_CH*CH_W-1:0] == '0));
endmodule

// File: rtl/alpha_over_blender.sv
module alpha_over_blender
  import blend_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        in_valid_i,
  output logic        in_ready_o,
  input  logic [1:0]  mode_i,
  input  logic [31:0] fg_pix_i,
  input  logic [31:0] bg_pix_i,
  output logic        out_valid_o,
  input  logic        out_ready_i,
  output logic [31:0] out_pix_o
);
  logic         adv;
  logic         v1, v2;
  alpha_stage_t s1;
  num_stage_t   s2;
  mode_t        out_mode;

  // whole pipe advances when the tail is empty or drained
  assign adv        = !out_valid_o || out_ready_i;
  assign in_ready_o = adv;

  blend_alpha_stage u_alpha (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (adv),
    .valid_i (in_valid_i),
    .mode_i  (mode_i),
    .fg_i    (fg_pix_i),
    .bg_i    (bg_pix_i),
    .valid_o (v1),
    .data_o  (s1)
  );

  blend_num_stage u_num (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (adv),
    .valid_i (v1),
    .data_i  (s1),
    .valid_o (v2),
    .data_o  (s2)
  );

  blend_div_stage u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (adv),
    .valid_i (v2),
    .data_i  (s2),
    .valid_o (out_valid_o),
    .mode_o  (out_mode),
    .pix_o   (out_pix_o)
  );

  assert_stall_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_pix_o) && $stable(out_mode)));
endmodule

// File: tb/alpha_over_blender_test.sv
module alpha_over_blender_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  mode = 2'b10;
  logic [31:0] fg = '0, bg = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_pix;

  int unsigned n_chk = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] held;

  always #10 clk = ~clk;

  alpha_over_blender uut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .mode_i(mode), .fg_pix_i(fg), .bg_pix_i(bg), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .out_pix_o(out_pix)
  );

  function automatic logic [31:0] model(logic [31:0] f, logic [31:0] b, logic [1:0] m);
    int af, ab, am, ao, num;
    logic [31:0] r;
    if (m != 2'b10) return f;
    af = int'(f[31:24]); ab = int'(b[31:24]);
    am = (af * ab) / 255;
    ao = af + ab - am;
    r = '0;
    r[31:24] = 8'(ao);
    for (int ch = 0; ch < 3; ch++) begin
      num = int'(f[ch*8 +: 8]) * af + int'(b[ch*8 +: 8]) * ab - int'(b[ch*8 +: 8]) * am;
      r[ch*8 +: 8] = (ao == 0) ? 8'd0 : 8'(num / ao);
    end
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(logic v, logic [31:0] f, logic [31:0] b, logic [1:0] m, logic rdy, string tag);
    @(negedge clk);
    in_valid = v; fg = f; bg = b; mode = m; out_ready = rdy;
    #1;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) check("R1 extra output", out_pix, 32'hx);
      else check(tag_q.pop_front(), out_pix, exp_q.pop_front());
    end
    if (in_valid && in_ready) begin
      exp_q.push_back(model(f, b, m));
      tag_q.push_back(tag);
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 20 && (exp_q.size() != 0 || out_valid); i++)
      step(1'b0, '0, '0, 2'b10, 1'b1, "R1 drain");
    check("R1 queue empty after drain", 32'(exp_q.size()), 32'd0);
  endtask

  function automatic logic [7:0] rnd_alpha();
    case ($urandom % 4)
      0: return 8'd0;
      1: return 8'd255;
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    check("R10 out_valid in reset", {31'd0, out_valid}, 32'd0);
    check("R10 in_ready in reset", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;

    // directed corners
    step(1, 32'h00_11_22_33, 32'h00_44_55_66, 2'b10, 1, "R6 both alpha zero");
    step(1, 32'hFF_10_20_30, 32'h80_AA_BB_CC, 2'b10, 1, "R4 opaque fg");
    step(1, 32'h00_10_20_30, 32'hFF_AA_BB_CC, 2'b10, 1, "R4 clear fg opaque bg");
    step(1, 32'h80_FF_00_7F, 32'h80_00_FF_7F, 2'b10, 1, "R2 R3 half alphas");
    step(1, 32'hFE_FF_FF_FF, 32'hFE_FF_FF_FF, 2'b10, 1, "R3 R5 near full");
    step(1, 32'h01_FF_FF_FF, 32'h01_00_00_00, 2'b10, 1, "R4 floor small alpha");
    step(1, 32'h00_12_34_56, 32'hFF_AB_CD_EF, 2'b00, 1, "R7 mode 00 pass");
    step(1, 32'h7A_12_34_56, 32'hFF_AB_CD_EF, 2'b01, 1, "R7 mode 01 pass");
    step(1, 32'hFF_01_02_03, 32'h00_AB_CD_EF, 2'b11, 1, "R7 mode 11 pass");
    drain();

    // R1 exact field positions
    check("R1 field positions", model(32'hFF_10_20_30, 32'h00_00_00_00, 2'b10), 32'hFF_10_20_30);

    // R8 latency
    step(1, 32'hC0_40_80_C0, 32'h40_C0_80_40, 2'b10, 1, "R8 latency pixel");
    begin
      int lat;
      lat = 0;
      for (int i = 1; i <= 6 && lat == 0; i++) begin
        step(0, '0, '0, 2'b10, 1, "R8 latency pixel");
        if (out_valid) lat = i;
      end
      check("R8 latency cycles", 32'(lat), 32'd3);
    end
    drain();

    // R8 full rate: every cycle accepted with ready high
    for (int i = 0; i < 8; i++) begin
      step(1, {rnd_alpha(), 24'($urandom)}, {rnd_alpha(), 24'($urandom)}, 2'b10, 1, "R8 back to back");
      check("R8 accept every cycle", {31'd0, in_ready}, 32'd1);
    end
    drain();

    // R9 back-pressure
    for (int i = 0; i < 3; i++)
      step(1, {8'(60 + i), 24'h336699}, {8'd200, 24'hCC9933}, 2'b10, 0, "R9 stalled pixel");
    step(1, 32'hFF_FF_FF_FF, 32'hFF_FF_FF_FF, 2'b10, 0, "R9 blocked pixel");
    check("R9 out_valid while stalled", {31'd0, out_valid}, 32'd1);
    check("R9 in_ready low while stalled", {31'd0, in_ready}, 32'd0);
    held = out_pix;
    step(1, 32'hFF_FF_FF_FF, 32'hFF_FF_FF_FF, 2'b10, 0, "R9 blocked pixel");
    check("R9 output stable", out_pix, held);
    check("R9 still valid", {31'd0, out_valid}, 32'd1);
    drain();

    // constrained random with random stalls
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] m;
      m = (($urandom % 4) == 0) ? 2'($urandom) : 2'b10;
      step(($urandom % 5) != 0, {rnd_alpha(), 24'($urandom)}, {rnd_alpha(), 24'($urandom)},
           m, ($urandom % 10) < 7, "R4 R7 random");
    end
    drain();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule